// File: doc/BRIEF.md
# SAR ADC Configuration and Calibration Controller

This block holds the byte-wide configuration register of a successive-approximation converter and runs the control logic behind it. The upper nibble sets the SAR conversion clock divider. The block emits a one-cycle enable pulse every (divider + 1) system clock cycles, and downstream converter logic advances on that pulse.

The three low bits start calibration cycles. Bit 0 starts offset calibration, bit 2 starts gain calibration and bit 1 starts linearity calibration. A write of 1 starts a calibration only when the converter reports idle and no other calibration is running. The same bit then reads back as a busy flag until the calibration engine pulses its done input. Bit 3 chooses between internal and external calibration voltages. A change to bit 3 made during a calibration is held back and takes effect when that calibration ends. The analog converter and the calibration arithmetic sit outside this block and are reached through simple request and done signals.

Top module: `adc_cal_ctrl`

## Requirements
- R1: After reset the register reads 0xF0, no request output or busy output is high, and the reference select output is 0.
- R2: The conversion enable output is high for one cycle out of every (N + 1) cycles, where N is register bits [7:4]. With N = 0 it is high on every cycle.
- R3: A write to the register loads N at once and restarts the divider count. The next enable pulse comes N + 1 cycles after the write edge.
- R4: Register bit 3 drives the reference select output (1 selects external voltages) and reads back unchanged, on the cycle after a write made while no calibration runs.
- R5: Writing 1 to bit 0, bit 2 or bit 1 while adc_idle is high and nothing is running starts offset, gain or linearity calibration. On the next cycle the matching request output and read bit go high, and so does adc_busy.
- R6: A start write is ignored while adc_idle is low or while a calibration is already running.
- R7: Writing 0 to a calibration bit has no effect, and a running calibration is not cleared by it.
- R8: At most one calibration runs. If several start bits are written together, offset wins over gain and gain wins over linearity.
- R9: A running calibration keeps adc_busy high. Its request and read bit clear on the cycle after cal_done is sampled high. cal_done has no effect while nothing runs.
- R10: A write to bit 3 during a calibration leaves the reference select output unchanged until the calibration ends. The most recently written value is applied on the same edge that clears the calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |
| adc_idle | input | 1 | Converter idle indication |
| cal_done | input | 1 | Calibration engine completion pulse |
| cal_req_off | output | 1 | Offset calibration request |
| cal_req_gain | output | 1 | Gain calibration request |
| cal_req_lin | output | 1 | Linearity calibration request |
| adc_busy | output | 1 | Calibration in progress |
| cal_ext_ref | output | 1 | Calibration voltage source select |
| sar_clk_en | output | 1 | SAR conversion clock enable pulse |

## Verification
The hardest case to reach is a reference-select write that arrives during a calibration and must stay invisible until the calibration completes. This case interacts with start writes that are rejected and with writes of zero, all made while the calibration runs. The stimulus starts a linearity calibration and then issues bit 3 writes alongside ignored start bits while the calibration is running. It ends with cal_done, and the output must change on the completion edge and on no earlier edge. A behavioural model checks every output on every cycle, so divider reloads that land next to enable pulses are covered too.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    // Calibration flags in register bit order: [2] gain, [1] linearity, [0] offset
    typedef struct packed {
        logic gain;
        logic lin;
        logic off;
    } cal_flags_t;

    // Fixed acceptance priority: offset, then gain, then linearity
    function automatic cal_flags_t cal_pick(input cal_flags_t req);
        cal_flags_t g;
        g = '0;
        if (req.off)       g.off  = 1'b1;
        else if (req.gain) g.gain = 1'b1;
        else if (req.lin)  g.lin  = 1'b1;
        return g;
    endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic [DIV_W-1:0] div_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.div = load_val;
            st_d.cnt = load_val;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = st_q.div;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div <= '1;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o  = st_q.div;
    assign tick_o = (st_q.cnt == '0);

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.div);

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && st_q.div != '0 && !load) |=> !tick_o);

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
    import adc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  cal_flags_t wr_start,
    input  logic       wr_ext,
    input  logic       adc_idle,
    input  logic       cal_done,
    output cal_flags_t flags_o,
    output logic       ext_ref_o
);
    typedef struct packed {
        cal_flags_t run;
        logic       ext;
        logic       pend;
        logic       pend_val;
    } cal_st_t;

    cal_st_t st_d, st_q;
    logic    busy;
    logic    pend_now;
    logic    pend_val_now;

    assign busy = |st_q.run;

    always_comb begin
        st_d         = st_q;
        pend_now     = st_q.pend;
        pend_val_now = st_q.pend_val;
        if (!busy) begin
            if (wr_en) begin
                st_d.ext  = wr_ext;
                st_d.pend = 1'b0;
                if (adc_idle) st_d.run = cal_pick(wr_start);
            end
        end else begin
            if (wr_en) begin
                pend_now     = 1'b1;
                pend_val_now = wr_ext;
            end
            st_d.pend     = pend_now;
            st_d.pend_val = pend_val_now;
            if (cal_done) begin
                st_d.run  = '0;
                st_d.pend = 1'b0;
                if (pend_now) st_d.ext = pend_val_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o   = st_q.run;
    assign ext_ref_o = st_q.ext;

    // R8
    one_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags_o));

    // R6
    not_idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !adc_idle) |=> (flags_o == '0));

    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_done) |=> (flags_o == '0));

    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cal_done) |=> $stable(flags_o));

    // R10
    ref_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cal_done) |=> $stable(ext_ref_o));

endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
    import adc_cal_pkg::*;
#(
    parameter int DIV_W = 4,
    localparam int REG_W = DIV_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             adc_idle,
    input  logic             cal_done,
    output logic             cal_req_off,
    output logic             cal_req_gain,
    output logic             cal_req_lin,
    output logic             adc_busy,
    output logic             cal_ext_ref,
    output logic             sar_clk_en
);
    localparam int EXT_BIT = 3;

    logic [DIV_W-1:0] div_val;
    cal_flags_t       flags;
    cal_flags_t       start_bits;

    assign start_bits = cal_flags_t'(reg_wr_data[2:0]);

    sar_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr_en),
        .load_val (reg_wr_data[REG_W-1:4]),
        .div_o    (div_val),
        .tick_o   (sar_clk_en)
    );

    cal_ctrl u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_start  (start_bits),
        .wr_ext    (reg_wr_data[EXT_BIT]),
        .adc_idle  (adc_idle),
        .cal_done  (cal_done),
        .flags_o   (flags),
        .ext_ref_o (cal_ext_ref)
    );

    assign reg_rd_data  = {div_val, cal_ext_ref, flags};
    assign cal_req_off  = flags.off;
    assign cal_req_gain = flags.gain;
    assign cal_req_lin  = flags.lin;
    assign adc_busy     = |flags;

    // R9
    busy_matches_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_busy == (cal_req_off || cal_req_gain || cal_req_lin));

    // R3
    div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data[REG_W-1:4] == $past(reg_wr_data[REG_W-1:4])));

endmodule

// File: tb/tb_adc_cal_ctrl.sv
module tb_adc_cal_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       adc_idle = 1'b1;
    logic       cal_done = 1'b0;
    logic       cal_req_off, cal_req_gain, cal_req_lin;
    logic       adc_busy, cal_ext_ref, sar_clk_en;

    always #2 clk = ~clk;

    adc_cal_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .adc_idle(adc_idle), .cal_done(cal_done),
        .cal_req_off(cal_req_off), .cal_req_gain(cal_req_gain), .cal_req_lin(cal_req_lin),
        .adc_busy(adc_busy), .cal_ext_ref(cal_ext_ref), .sar_clk_en(sar_clk_en)
    );

    int checks = 0;
    int fails = 0;
    // model state: m_cal 0 none, 1 offset, 2 gain, 3 linearity
    int m_div = 15, m_cnt = 15, m_cal = 0, m_ext = 0, m_pend = 0, m_pval = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int rd;
        int req;
        rd  = (m_div << 4) | (m_ext << 3) | ((m_cal == 2) << 2) | ((m_cal == 3) << 1) | (m_cal == 1);
        req = ((m_cal == 1) << 2) | ((m_cal == 2) << 1) | (m_cal == 3);
        chk(tag, "rd_data", int'(reg_rd_data), rd);
        chk(tag, "sar_clk_en", int'(sar_clk_en), int'(m_cnt == 0));
        chk(tag, "req{off,gain,lin}", int'({cal_req_off, cal_req_gain, cal_req_lin}), req);
        chk(tag, "adc_busy", int'(adc_busy), int'(m_cal != 0));
        chk(tag, "ext_ref", int'(cal_ext_ref), m_ext);
    endtask

    task automatic model_step(input logic we, input logic [7:0] wd, input logic idle, input logic done);
        int busy;
        busy = (m_cal != 0);
        if (we) begin
            m_div = int'(wd[7:4]);
            m_cnt = m_div;
        end else if (m_cnt == 0) m_cnt = m_div;
        else m_cnt = m_cnt - 1;
        if (busy == 0) begin
            if (we) begin
                m_ext = int'(wd[3]);
                m_pend = 0;
                if (idle) begin
                    if (wd[0]) m_cal = 1;
                    else if (wd[2]) m_cal = 2;
                    else if (wd[1]) m_cal = 3;
                end
            end
        end else begin
            if (we) begin
                m_pend = 1;
                m_pval = int'(wd[3]);
            end
            if (done) begin
                m_cal = 0;
                if (m_pend != 0) m_ext = m_pval;
                m_pend = 0;
            end
        end
    endtask

    task automatic cyc(input logic we, input logic [7:0] wd, input logic idle,
                       input logic done, input string tag);
        @(negedge clk);
        compare(tag);
        reg_wr_en = we; reg_wr_data = wd; adc_idle = idle; cal_done = done;
        model_step(we, wd, idle, done);
    endtask

    task automatic idle_n(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0, tag);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_step(1'b0, 8'h00, 1'b1, 1'b0);
        // R1 reset state, R2 divide by 16
        idle_n(1, "R1");
        idle_n(34, "R2");
        // R3 reload to N=2, then N=0
        cyc(1'b1, 8'h20, 1'b1, 1'b0, "R3");
        idle_n(9, "R3");
        cyc(1'b1, 8'h00, 1'b1, 1'b0, "R2");
        idle_n(4, "R2");
        cyc(1'b1, 8'h50, 1'b1, 1'b0, "R3");
        idle_n(3, "R3");
        // R4 reference select
        cyc(1'b1, 8'h38, 1'b1, 1'b0, "R4");
        idle_n(2, "R4");
        cyc(1'b1, 8'h30, 1'b1, 1'b0, "R4");
        idle_n(2, "R4");
        // R6 rejected while converter not idle
        cyc(1'b1, 8'h31, 1'b0, 1'b0, "R6");
        idle_n(2, "R6");
        // R5 offset start, R6 second start ignored, R7 zero write no effect
        cyc(1'b1, 8'h31, 1'b1, 1'b0, "R5");
        idle_n(2, "R5");
        cyc(1'b1, 8'h34, 1'b1, 1'b0, "R6");
        cyc(1'b1, 8'h30, 1'b1, 1'b0, "R7");
        idle_n(3, "R7");
        // R9 completion
        cyc(1'b0, 8'h00, 1'b1, 1'b1, "R9");
        idle_n(2, "R9");
        cyc(1'b0, 8'h00, 1'b1, 1'b1, "R9");
        idle_n(2, "R9");
        // R5 gain and linearity
        cyc(1'b1, 8'h14, 1'b1, 1'b0, "R5");
        idle_n(3, "R5");
        cyc(1'b0, 8'h00, 1'b1, 1'b1, "R9");
        cyc(1'b1, 8'h12, 1'b1, 1'b0, "R5");
        idle_n(3, "R5");
        cyc(1'b0, 8'h00, 1'b1, 1'b1, "R9");
        idle_n(1, "R9");
        // R8 priority
        cyc(1'b1, 8'h17, 1'b1, 1'b0, "R8");
        idle_n(2, "R8");
        cyc(1'b0, 8'h00, 1'b1, 1'b1, "R8");
        cyc(1'b1, 8'h16, 1'b1, 1'b0, "R8");
        idle_n(2, "R8");
        cyc(1'b0, 8'h00, 1'b1, 1'b1, "R8");
        idle_n(1, "R8");
        // R10 deferred reference change
        cyc(1'b1, 8'h22, 1'b1, 1'b0, "R10");
        idle_n(1, "R10");
        cyc(1'b1, 8'h29, 1'b1, 1'b0, "R10");
        idle_n(3, "R10");
        cyc(1'b1, 8'h2C, 1'b0, 1'b0, "R10");
        idle_n(2, "R10");
        cyc(1'b0, 8'h00, 1'b1, 1'b1, "R10");
        idle_n(2, "R10");
        // R10 write on completion cycle wins
        cyc(1'b1, 8'h21, 1'b1, 1'b0, "R10");
        cyc(1'b1, 8'h20, 1'b1, 1'b1, "R10");
        idle_n(3, "R10");
        finish_run();
    end
endmodule